// File: doc/BRIEF.md
# Memory Bring-Up Sequencer

This block runs on the host side next to an attached synchronous memory device and walks that device from power-up to normal use. It holds the device in reset for a fixed number of cycles. It then waits out the device's calibration window and turns the device PLL on, either through a dedicated pin or through a configuration register bit. After that it waits for lock. When the system asks for training, the sequencer hands control in turn to three external training engines, one per training phase. It then issues the configuration register write that selects the 5-cycle read latency. Only after that write has been accepted does it raise `ready`.

Each wait phase uses a down-counter that is loaded with the phase's worst-case bound, so the device's own timing is always covered. A phase ends as soon as its early-done input is seen or its counter runs out. While `ready` is high, a retrain request drops `ready` and restarts the training chain. Register writes and training go through simple hold-until-acknowledged handshakes with neighbouring blocks.

Top module: `mem_bringup_seq`

## Requirements
- R1: After `rst_n` is released, `dev_rst` stays high for exactly RST_CYCLES clocks. While it is high, `ready`, `trn_go`, `cfg_wr_vld` and `pll_en` are all low.
- R2: The calibration wait begins in the cycle after `dev_rst` falls. It lasts until the first cycle in which `cal_done` is high, or for CAL_MAX cycles, whichever comes first. `cal_done` has no effect in any other phase.
- R3: Configuration writes use register select CFG_SEL. The data bits are: [0] PLL enable, [1] latency select (0 selects 5 cycles), [4:2] fixed at 3'b100, [5] zero. When `use_reg_pll` is 1, a write of 6'b010011 is issued right after calibration and held until `cfg_wr_ack`, and `pll_en` stays low.
- R4: When `use_reg_pll` is 0, `pll_en` rises in the first cycle after calibration ends. It stays high until `rst_n` is asserted.
- R5: The lock wait starts after the PLL has been turned on. It lasts until `pll_lock` is high, or for LOCK_MAX cycles.
- R6: Training runs in a fixed order of phases, with `trn_phase` set as follows: address/control (0), then read data (1), then write data (2). `trn_go` is high throughout training, and each phase is held until `trn_done`.
- R7: If `train_again` is high when the write-data phase completes, training restarts at the address/control phase.
- R8: If `train_req` is low when the lock wait ends, training is skipped and the latency write follows at once.
- R9: Before `ready` can rise, a write of latency select 0 is issued, with data 6'b01000p where p equals `use_reg_pll`, and that write is acknowledged.
- R10: `ready` rises in the cycle after the latency write is acknowledged. It stays high until a retrain request.
- R11: `retrain_req` while `ready` is high drops `ready` in the next cycle and starts training at the address/control phase. The latency write is repeated afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| use_reg_pll | input | 1 | 1: enable the PLL by register write; 0: by pin |
| cal_done | input | 1 | Early end of calibration wait |
| pll_lock | input | 1 | Early end of lock wait |
| train_req | input | 1 | Training wanted after lock |
| train_again | input | 1 | Repeat training after write-data phase |
| retrain_req | input | 1 | Re-enter training from ready |
| trn_done | input | 1 | Current training phase finished |
| cfg_wr_ack | input | 1 | Register write accepted |
| dev_rst | output | 1 | Device reset, active high |
| pll_en | output | 1 | Device PLL enable pin |
| trn_go | output | 1 | Training phase active |
| trn_phase | output | 2 | Training phase code |
| cfg_wr_vld | output | 1 | Register write request |
| cfg_wr_sel | output | 4 | Register select |
| cfg_wr_data | output | 6 | Register data |
| ready | output | 1 | Device ready for normal use |

## Verification
The sequence is run twice. The first run uses register-enabled PLL mode, lets both waits end on their counters, trains, retrains and repeats training. Only this run can show that the wait bounds are exact and that the training chain returns to phase 0. The second run uses pin mode, ends both waits early and skips training. It separates the early-exit path and the skip path from the default path. In the second run, stray `cal_done`, `pll_lock` and `trn_done` pulses are applied in phases where they must have no effect.

// File: rtl/mem_bringup_seq.sv
module mem_bringup_seq #(
  parameter int RST_CYCLES = 16,
  parameter int CAL_MAX    = 393216,
  parameter int LOCK_MAX   = 65536,
  parameter logic [3:0] CFG_SEL = 4'd1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       use_reg_pll,
  input  logic       cal_done,
  input  logic       pll_lock,
  input  logic       train_req,
  input  logic       train_again,
  input  logic       retrain_req,
  input  logic       trn_done,
  input  logic       cfg_wr_ack,
  output logic       dev_rst,
  output logic       pll_en,
  output logic       trn_go,
  output logic [1:0] trn_phase,
  output logic       cfg_wr_vld,
  output logic [3:0] cfg_wr_sel,
  output logic [5:0] cfg_wr_data,
  output logic       ready
);
  localparam int BIG = (CAL_MAX > LOCK_MAX) ? ((CAL_MAX > RST_CYCLES) ? CAL_MAX : RST_CYCLES)
                                            : ((LOCK_MAX > RST_CYCLES) ? LOCK_MAX : RST_CYCLES);
  localparam int CW = $clog2(BIG + 1);

  typedef enum logic [3:0] {
    S_RST, S_CAL, S_PREG, S_LOCK, S_TAC, S_TRD, S_TWR, S_CFG, S_RDY
  } st_t;

  st_t st, nx;
  logic [CW-1:0] cnt;
  logic pll_pin_q;
  wire expired = (cnt == '0);

  always_comb begin
    nx = st;
    case (st)
      S_RST:  if (expired) nx = S_CAL;
      S_CAL:  if (cal_done || expired) nx = use_reg_pll ? S_PREG : S_LOCK;
      S_PREG: if (cfg_wr_ack) nx = S_LOCK;
      S_LOCK: if (pll_lock || expired) nx = train_req ? S_TAC : S_CFG;
      S_TAC:  if (trn_done) nx = S_TRD;
      S_TRD:  if (trn_done) nx = S_TWR;
      S_TWR:  if (trn_done) nx = train_again ? S_TAC : S_CFG;
      S_CFG:  if (cfg_wr_ack) nx = S_RDY;
      S_RDY:  if (retrain_req) nx = S_TAC;
      default: nx = S_RST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_RST;
      cnt       <= CW'(RST_CYCLES - 1);
      pll_pin_q <= 1'b0;
    end else begin
      st <= nx;
      if (st != nx && nx == S_CAL)       cnt <= CW'(CAL_MAX - 1);
      else if (st != nx && nx == S_LOCK) cnt <= CW'(LOCK_MAX - 1);
      else if (!expired)                 cnt <= cnt - 1'b1;
      if (st == S_CAL && nx != S_CAL && !use_reg_pll) pll_pin_q <= 1'b1;
    end
  end

  assign dev_rst    = (st == S_RST);
  assign pll_en     = pll_pin_q;
  assign trn_go     = (st == S_TAC) || (st == S_TRD) || (st == S_TWR);
  assign trn_phase  = (st == S_TRD) ? 2'd1 : (st == S_TWR) ? 2'd2 : 2'd0;
  assign cfg_wr_vld = (st == S_PREG) || (st == S_CFG);
  assign cfg_wr_sel = cfg_wr_vld ? CFG_SEL : 4'd0;
  assign cfg_wr_data = (st == S_PREG) ? 6'b010011 :
                       (st == S_CFG)  ? {5'b01000, use_reg_pll} : 6'd0;
  assign ready      = (st == S_RDY);
endmodule

// File: rtl/mem_bringup_seq_chk.sv
module mem_bringup_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       trn_done,
  input logic       retrain_req,
  input logic       cfg_wr_ack,
  input logic       dev_rst,
  input logic       pll_en,
  input logic       trn_go,
  input logic [1:0] trn_phase,
  input logic       cfg_wr_vld,
  input logic [5:0] cfg_wr_data,
  input logic       ready
);
  a_r1_rst_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst |-> !ready && !trn_go && !cfg_wr_vld && !pll_en);
  a_r4_pin_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pll_en |=> pll_en);
  a_r3_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_vld |-> cfg_wr_data[5:2] == 4'b0100);
  a_r6_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    trn_go && !trn_done |=> trn_go && $stable(trn_phase));
  a_r6_ac_then_rd: assert property (@(posedge clk) disable iff (!rst_n)
    trn_go && trn_done && trn_phase == 2'd0 |=> trn_go && trn_phase == 2'd1);
  a_r6_rd_then_wr: assert property (@(posedge clk) disable iff (!rst_n)
    trn_go && trn_done && trn_phase == 2'd1 |=> trn_go && trn_phase == 2'd2);
  a_r9_latency_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(cfg_wr_vld && cfg_wr_ack && !cfg_wr_data[1]));
  a_r10_ready_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ready && !retrain_req |=> ready);
  a_r11_retrain: assert property (@(posedge clk) disable iff (!rst_n)
    ready && retrain_req |=> !ready && trn_go && trn_phase == 2'd0);
endmodule

bind mem_bringup_seq mem_bringup_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .trn_done(trn_done), .retrain_req(retrain_req),
  .cfg_wr_ack(cfg_wr_ack), .dev_rst(dev_rst), .pll_en(pll_en), .trn_go(trn_go),
  .trn_phase(trn_phase), .cfg_wr_vld(cfg_wr_vld), .cfg_wr_data(cfg_wr_data),
  .ready(ready)
);

// File: tb/tb_mem_bringup_seq.sv
module tb_mem_bringup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int RSTC = 4, CALM = 30, LOCKM = 12;

  logic clk = 0, rst_n = 0;
  logic use_reg_pll = 1, cal_done = 0, pll_lock = 0, train_req = 0, train_again = 0;
  logic retrain_req = 0, trn_done = 0, cfg_wr_ack = 0;
  logic dev_rst, pll_en, trn_go, cfg_wr_vld, ready;
  logic [1:0] trn_phase;
  logic [3:0] cfg_wr_sel;
  logic [5:0] cfg_wr_data;

  mem_bringup_seq #(.RST_CYCLES(RSTC), .CAL_MAX(CALM), .LOCK_MAX(LOCKM), .CFG_SEL(4'd1)) dut (
    .clk(clk), .rst_n(rst_n), .use_reg_pll(use_reg_pll), .cal_done(cal_done),
    .pll_lock(pll_lock), .train_req(train_req), .train_again(train_again),
    .retrain_req(retrain_req), .trn_done(trn_done), .cfg_wr_ack(cfg_wr_ack),
    .dev_rst(dev_rst), .pll_en(pll_en), .trn_go(trn_go), .trn_phase(trn_phase),
    .cfg_wr_vld(cfg_wr_vld), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
    .ready(ready));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0, n_bad = 0, cycles = 0;
  bit finished = 0;

  // Reference model: phase names 0 rst,1 cal,2 pll write,3 lock,4 ac,5 rd,6 wr,7 cfg,8 ready
  int mph = 0, mcnt = 0;
  bit mpll = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin mph <= 0; mcnt <= 0; mpll <= 0; end
    else case (mph)
      0: if (mcnt == RSTC-1) begin mph <= 1; mcnt <= 0; end else mcnt <= mcnt + 1;
      1: if (cal_done || mcnt == CALM-1) begin
           mph <= use_reg_pll ? 2 : 3; mcnt <= 0;
           if (!use_reg_pll) mpll <= 1;
         end else mcnt <= mcnt + 1;
      2: if (cfg_wr_ack) begin mph <= 3; mcnt <= 0; end
      3: if (pll_lock || mcnt == LOCKM-1) mph <= train_req ? 4 : 7; else mcnt <= mcnt + 1;
      4: if (trn_done) mph <= 5;
      5: if (trn_done) mph <= 6;
      6: if (trn_done) mph <= train_again ? 4 : 7;
      7: if (cfg_wr_ack) mph <= 8;
      8: if (retrain_req) mph <= 4;
      default: mph <= 0;
    endcase
  end

  task automatic check(input string req, input int act, input int exp_v);
    n_vec++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at t=%0t", req, act, exp_v, $time);
    end
  endtask

  always @(negedge clk) if (!finished) begin
    check("R1 dev_rst", dev_rst, mph == 0);
    check("R4 pll_en", pll_en, mpll);
    check("R6 trn_go", trn_go, mph >= 4 && mph <= 6);
    if (mph >= 4 && mph <= 6) check("R6 trn_phase", trn_phase, mph - 4);
    check("R3 cfg_wr_vld", cfg_wr_vld, mph == 2 || mph == 7);
    if (mph == 2) begin
      check("R3 pll write data", cfg_wr_data, 6'b010011);
      check("R3 sel", cfg_wr_sel, 1);
    end
    if (mph == 7) check("R9 latency write data", cfg_wr_data, {5'b01000, use_reg_pll});
    check("R10 ready", ready, mph == 8);
  end

  task automatic step(); @(posedge clk); #1; endtask

  task automatic summary();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 20000) begin
        n_bad++; $display("FAIL watchdog expired");
        summary();
      end
    end
  end

  task automatic ack_cfg();
    while (!cfg_wr_vld) step();
    repeat (2) step();
    cfg_wr_ack = 1; step(); cfg_wr_ack = 0;
  endtask

  task automatic finish_phase(input int ph);
    while (!(trn_go && trn_phase == 2'(ph))) step();
    repeat (3) step();
    trn_done = 1; step(); trn_done = 0;
  endtask

  initial begin
    int n;
    bit saw;
    // Run 1: register PLL mode, counters expire, training with repeat
    use_reg_pll = 1; train_req = 1;
    repeat (2) @(posedge clk); #1; rst_n = 1;
    n = 0; while (dev_rst) begin step(); n++; end
    check("R1 reset length", n, RSTC);
    n = 0; while (!cfg_wr_vld) begin step(); n++; end
    check("R2 cal bound", n, CALM);
    check("R3 pll pin stays low", pll_en, 0);
    repeat (2) step(); cfg_wr_ack = 1; step(); cfg_wr_ack = 0;
    n = 0; while (!trn_go) begin step(); n++; end
    check("R5 lock bound", n, LOCKM);
    finish_phase(0); finish_phase(1);
    train_again = 1; finish_phase(2); train_again = 0;
    check("R7 back to ac", trn_phase, 0);
    check("R7 trn_go", trn_go, 1);
    finish_phase(0); finish_phase(1); finish_phase(2);
    ack_cfg();
    check("R10 ready after ack", ready, 1);
    repeat (5) step();
    retrain_req = 1; step(); retrain_req = 0;
    check("R11 ready dropped", ready, 0);
    check("R11 restart ac", trn_phase, 0);
    finish_phase(0); finish_phase(1); finish_phase(2);
    ack_cfg();
    check("R11 ready again", ready, 1);

    // Run 2: pin mode, early done, no training, stray pulses
    rst_n = 0; use_reg_pll = 0; train_req = 0; step(); rst_n = 1;
    cal_done = 1; pll_lock = 1; trn_done = 1; step(); cal_done = 0; pll_lock = 0; trn_done = 0;
    while (dev_rst) step();
    repeat (3) step();
    cal_done = 1; step(); cal_done = 0;
    check("R4 pll_en raised", pll_en, 1);
    check("R2 early cal exit", cfg_wr_vld, 0);
    repeat (2) step();
    pll_lock = 1; step(); pll_lock = 0;
    saw = 0; n = 0;
    while (!cfg_wr_vld) begin if (trn_go) saw = 1; step(); n++; end
    check("R8 training skipped", saw, 0);
    check("R5 early lock exit", n, 0);
    cal_done = 1; pll_lock = 1; trn_done = 1; step(); cal_done = 0; pll_lock = 0; trn_done = 0;
    check("R2 stray pulses ignored", cfg_wr_vld, 1);
    ack_cfg();
    check("R9 ready after latency write", ready, 1);
    repeat (4) step();
    summary();
  end
endmodule